// File: doc/BRIEF.md
# Sign-Magnitude Multiply-Accumulate with Deferred Increment

This block is a purely combinational multiply-accumulate stage that evaluates A·B + C. All three operands and the result are fixed-point words in sign-magnitude form. The top bit is the sign, and the remaining bits are a fraction. The two operand magnitudes are multiplied exactly. The exact product is then truncated to the upper half of its fraction bits, and the addend magnitude is added to or subtracted from it according to the signs.

The partial products, the addend row and a small correction row all enter one carry-save (Wallace) compression tree. A single merge adder then resolves the tree output to two's complement. A parameter picks the merge adder architecture: ripple-carry, blocked carry-lookahead, carry-select or parallel-prefix. Nothing else in the datapath changes with that choice.

When the merged result is negative, the magnitude is inverted but is not incremented. The missing +1 leaves the block as a residual bit, and a later stage (for example the final output of a filter) adds it back. In a chain of these units, only the last stage then pays for the extra carry propagation.

Top module: `smac_unit`

## Requirements
- R1: Each word is 17 bits wide. Bit 16 is the sign (1 means negative) and bits 15:0 are the magnitude as a fraction. The product magnitude used by the block is floor(magA·magB / 2^16).
- R2: When sign(A) XOR sign(B) equals sign(C) and P + magC ≤ 65535, where P is the truncated product, the following hold. The output magnitude is P + magC. The output sign is sign(A) XOR sign(B). The residual bit is 0.
- R3: When the signs differ and P ≥ magC, the following hold. The output magnitude is P − magC. The output sign is sign(A) XOR sign(B). The residual bit is 0.
- R4: When the signs differ and P < magC, the following hold. The residual bit is 1. The output magnitude is magC − P − 1, so that the true magnitude is the output magnitude plus the residual bit. The output sign is sign(C). This includes the case P = magC − 1, which gives magnitude 0 with residual 1 and sign(C).
- R5: A result with magnitude 0 and residual 0 always has sign 0. This holds for any input signs, including negative-zero operands.
- R6: When the signs agree and P + magC exceeds 65535, the output magnitude saturates to 0xFFFF. The sign stays sign(A) XOR sign(B) and the residual bit is 0.
- R7: All four merge adder choices give identical outputs for every input.
- R8: The outputs are a combinational function of the current inputs and settle within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 17 | Multiplicand, sign-magnitude (bit 16 is the sign) |
| b_i | input | 17 | Multiplier, sign-magnitude |
| c_i | input | 17 | Addend, sign-magnitude |
| y_o | output | 17 | Result: sign in bit 16, uncorrected magnitude in bits 15:0 |
| res_o | output | 1 | Residual bit that must be added to the magnitude later |

## Verification
The hardest situation to reach from the ports is a subtraction whose merged result is exactly −1. In that case the block reports magnitude 0 with residual 1, and it must keep the addend's sign rather than apply the zero-sign rule. The stimulus reaches it by choosing the product operands first and then setting the addend magnitude to the truncated product plus one. The saturation edge is reached with full-scale magnitudes on both multiplier inputs. The bench drives the same vectors into all four merge adder variants side by side, and a pseudo-random sweep compares every variant against the arithmetic rules.

// File: rtl/smac_pkg.sv
package smac_pkg;

    localparam int MAG_W_DEF = 16;

    typedef enum logic [1:0] {
        ARCH_RIPPLE    = 2'd0,
        ARCH_LOOKAHEAD = 2'd1,
        ARCH_SELECT    = 2'd2,
        ARCH_PREFIX    = 2'd3
    } merge_arch_e;

    // Sign information carried from operand decode to the output stage.
    typedef struct packed {
        logic prod_neg;   // sign of A*B
        logic add_neg;    // sign of C
    } sign_ctl_t;

    // Rows left after lvl levels of 3:2 compression.
    function automatic int rows_after(input int n0, input int lvl);
        int n;
        n = n0;
        for (int i = 0; i < lvl; i++) begin
            if (n > 2) n = n - n / 3;
        end
        return n;
    endfunction

    // Number of 3:2 levels needed to reach two rows.
    function automatic int tree_levels(input int n0);
        int n;
        int cnt;
        n   = n0;
        cnt = 0;
        while (n > 2) begin
            n   = n - n / 3;
            cnt = cnt + 1;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/smac_csa_tree.sv
module smac_csa_tree
    import smac_pkg::*;
#(
    parameter int W    = 34,
    parameter int ROWS = 18
) (
    input  logic [ROWS-1:0][W-1:0] rows_i,
    output logic [W-1:0]           sum_o,
    output logic [W-1:0]           carry_o
);

    localparam int LEVELS = tree_levels(ROWS);

    for (genvar l = 0; l <= LEVELS; l++) begin : lv
        localparam int N = rows_after(ROWS, l);
        logic [W-1:0] r [N];

        if (l == 0) begin : g_in
            for (genvar k = 0; k < N; k++) begin : g_k
                assign r[k] = rows_i[k];
            end
        end else begin : g_red
            localparam int NP = rows_after(ROWS, l - 1);
            localparam int G  = NP / 3;
            for (genvar g = 0; g < G; g++) begin : g_fa
                logic [W-1:0] x, y, z;
                assign x = lv[l-1].r[3*g];
                assign y = lv[l-1].r[3*g+1];
                assign z = lv[l-1].r[3*g+2];
                assign r[2*g]   = x ^ y ^ z;
                assign r[2*g+1] = ((x & y) | (x & z) | (y & z)) << 1;
            end
            for (genvar k = 3*G; k < NP; k++) begin : g_pass
                assign r[2*G + k - 3*G] = lv[l-1].r[k];
            end
        end
    end

    assign sum_o   = lv[LEVELS].r[0];
    assign carry_o = lv[LEVELS].r[1];

    // The two tree outputs must add to the sum of every input row (mod 2^W).
    always_comb begin
        logic [W-1:0] ref_sum;
        ref_sum = '0;
        for (int k = 0; k < ROWS; k++) ref_sum = ref_sum + rows_i[k];
        if (!$isunknown(rows_i)) begin
            AST_TREE_SUM: assert (W'(sum_o + carry_o) == ref_sum); // R1
        end
    end

endmodule

// File: rtl/smac_merge_add.sv
module smac_merge_add
    import smac_pkg::*;
#(
    parameter int          W    = 34,
    parameter merge_arch_e ARCH = ARCH_RIPPLE,
    parameter int          GS   = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] s_o
);

    localparam int NG = (W + GS - 1) / GS;
    localparam int WP = NG * GS;

    logic [WP-1:0] ap, bp, sp;

    assign ap  = WP'(a_i);
    assign bp  = WP'(b_i);
    assign s_o = sp[W-1:0];

    if (ARCH == ARCH_RIPPLE) begin : g_rc
        always_comb begin
            logic c;
            c = 1'b0;
            for (int i = 0; i < WP; i++) begin
                sp[i] = ap[i] ^ bp[i] ^ c;
                c     = (ap[i] & bp[i]) | (c & (ap[i] ^ bp[i]));
            end
        end
    end else if (ARCH == ARCH_LOOKAHEAD) begin : g_cla
        always_comb begin
            logic gc, cc, gg, gp, gi, pi;
            gc = 1'b0;
            for (int grp = 0; grp < NG; grp++) begin
                gg = 1'b0;
                gp = 1'b1;
                cc = gc;
                for (int j = 0; j < GS; j++) begin
                    gi = ap[grp*GS+j] & bp[grp*GS+j];
                    pi = ap[grp*GS+j] ^ bp[grp*GS+j];
                    sp[grp*GS+j] = pi ^ cc;
                    cc = gi | (pi & cc);
                    gg = gi | (pi & gg);
                    gp = gp & pi;
                end
                gc = gg | (gp & gc);
            end
        end
    end else if (ARCH == ARCH_SELECT) begin : g_csel
        always_comb begin
            logic          c;
            logic [GS:0]   s0, s1;
            c = 1'b0;
            for (int grp = 0; grp < NG; grp++) begin
                s0 = {1'b0, ap[grp*GS +: GS]} + {1'b0, bp[grp*GS +: GS]};
                s1 = {1'b0, ap[grp*GS +: GS]} + {1'b0, bp[grp*GS +: GS]} + 1'b1;
                sp[grp*GS +: GS] = c ? s1[GS-1:0] : s0[GS-1:0];
                c = c ? s1[GS] : s0[GS];
            end
        end
    end else begin : g_pfx
        always_comb begin
            logic [WP-1:0] g, p, gn, pn, p0;
            g  = ap & bp;
            p  = ap ^ bp;
            p0 = p;
            for (int d = 1; d < WP; d = d * 2) begin
                gn = g;
                pn = p;
                for (int i = d; i < WP; i++) begin
                    gn[i] = g[i] | (p[i] & g[i-d]);
                    pn[i] = p[i] & p[i-d];
                end
                g = gn;
                p = pn;
            end
            sp = p0 ^ {g[WP-2:0], 1'b0};
        end
    end

    // Every architecture must match plain addition over the padded width.
    always_comb begin
        if (!$isunknown({ap, bp})) begin
            AST_MERGE_EQ: assert (sp == WP'(ap + bp)); // R7
        end
    end

endmodule

// File: rtl/smac_post.sv
module smac_post
    import smac_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic [MAG_W+1:0] d_i,
    input  sign_ctl_t        ctl_i,
    output logic [MAG_W:0]   y_o,
    output logic             res_o
);

    logic             neg;
    logic [MAG_W:0]   raw;
    logic             ovf;
    logic [MAG_W-1:0] mag;
    logic             sgn;
    logic             is_zero;

    assign neg     = d_i[MAG_W+1];
    assign raw     = d_i[MAG_W:0] ^ {(MAG_W+1){neg}};
    assign ovf     = !neg && raw[MAG_W];
    assign mag     = ovf ? '1 : raw[MAG_W-1:0];
    assign sgn     = neg ? ctl_i.add_neg : ctl_i.prod_neg;
    assign is_zero = (mag == '0) && !neg;
    assign y_o     = {sgn & !is_zero, mag};
    assign res_o   = neg;

    always_comb begin
        if (!$isunknown({d_i, ctl_i})) begin
            AST_RES_SIGN: assert (!res_o || (y_o[MAG_W] == ctl_i.add_neg)); // R4
            AST_RES_NO_SAT: assert (!res_o || (y_o[MAG_W-1:0] != '1)); // R6
            AST_ZERO_POS: assert (!((y_o[MAG_W-1:0] == '0) && !res_o) || !y_o[MAG_W]); // R5
        end
    end

endmodule

// File: rtl/smac_unit.sv
module smac_unit
    import smac_pkg::*;
#(
    parameter int          MAG_W = MAG_W_DEF,
    parameter merge_arch_e ARCH  = ARCH_RIPPLE,
    parameter int          GS    = 4
) (
    input  logic [MAG_W:0] a_i,
    input  logic [MAG_W:0] b_i,
    input  logic [MAG_W:0] c_i,
    output logic [MAG_W:0] y_o,
    output logic           res_o
);

    localparam int PW   = 2 * MAG_W;
    localparam int TW   = PW + 2;
    localparam int ROWS = MAG_W + 2;
    localparam int DW   = MAG_W + 2;

    logic [MAG_W-1:0]         a_mag, b_mag, c_mag;
    sign_ctl_t                ctl;
    logic                     sub;
    logic [ROWS-1:0][TW-1:0]  rows;
    logic [TW-1:0]            cs_sum, cs_carry, merged;
    logic [TW-1:0]            c_row;
    logic [DW-1:0]            d_val;

    assign a_mag        = a_i[MAG_W-1:0];
    assign b_mag        = b_i[MAG_W-1:0];
    assign c_mag        = c_i[MAG_W-1:0];
    assign ctl.prod_neg = a_i[MAG_W] ^ b_i[MAG_W];
    assign ctl.add_neg  = c_i[MAG_W];
    assign sub          = ctl.prod_neg ^ ctl.add_neg;

    // Partial product rows.
    for (genvar k = 0; k < MAG_W; k++) begin : g_pp
        assign rows[k] = b_mag[k] ? (TW'(a_mag) << k) : '0;
    end

    // Addend aligned to the truncation point; negated as ~x plus a unit row.
    assign c_row          = TW'(c_mag) << MAG_W;
    assign rows[MAG_W]    = sub ? ~c_row : c_row;
    assign rows[MAG_W+1]  = TW'(sub);

    smac_csa_tree #(
        .W    (TW),
        .ROWS (ROWS)
    ) u_tree (
        .rows_i  (rows),
        .sum_o   (cs_sum),
        .carry_o (cs_carry)
    );

    smac_merge_add #(
        .W    (TW),
        .ARCH (ARCH),
        .GS   (GS)
    ) u_merge (
        .a_i (cs_sum),
        .b_i (cs_carry),
        .s_o (merged)
    );

    assign d_val = merged[TW-1:MAG_W];

    smac_post #(
        .MAG_W (MAG_W)
    ) u_post (
        .d_i   (d_val),
        .ctl_i (ctl),
        .y_o   (y_o),
        .res_o (res_o)
    );

    always_comb begin
        logic [PW-1:0] full_prod;
        full_prod = PW'(a_mag) * PW'(b_mag);
        if (!$isunknown({a_i, b_i, c_i})) begin
            AST_LOW_PROD: assert (merged[MAG_W-1:0] == full_prod[MAG_W-1:0]); // R1
            AST_ADD_NO_RES: assert (sub || !res_o); // R2
            AST_ADD_GROWS: assert (sub || (y_o[MAG_W-1:0] >= c_mag)); // R2
        end
    end

endmodule

// File: tb/sim_smac_unit.sv
`timescale 1ns/1ps
module sim_smac_unit;
    import smac_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [16:0] a, b, c;
    logic [16:0] y0, y1, y2, y3;
    logic        r0, r1, r2, r3;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    smac_unit #(.ARCH(ARCH_RIPPLE))    u0 (.a_i(a), .b_i(b), .c_i(c), .y_o(y0), .res_o(r0));
    smac_unit #(.ARCH(ARCH_LOOKAHEAD)) u1 (.a_i(a), .b_i(b), .c_i(c), .y_o(y1), .res_o(r1));
    smac_unit #(.ARCH(ARCH_SELECT))    u2 (.a_i(a), .b_i(b), .c_i(c), .y_o(y2), .res_o(r2));
    smac_unit #(.ARCH(ARCH_PREFIX))    u3 (.a_i(a), .b_i(b), .c_i(c), .y_o(y3), .res_o(r3));

    // Expected {sign, magnitude, residual} from the stated arithmetic rules.
    function automatic logic [17:0] model(input logic [16:0] xa, xb, xc);
        longint p, mc, s;
        logic   sab, sc, sg, rs;
        logic [15:0] m;
        p   = (longint'(xa[15:0]) * longint'(xb[15:0])) >>> 16;
        mc  = longint'(xc[15:0]);
        sab = xa[16] ^ xb[16];
        sc  = xc[16];
        if (sab == sc) begin
            s  = p + mc;
            m  = (s > 65535) ? 16'hFFFF : 16'(s);
            rs = 1'b0;
            sg = sab;
        end else if (p >= mc) begin
            m  = 16'(p - mc);
            rs = 1'b0;
            sg = sab;
        end else begin
            m  = 16'(mc - p - 1);
            rs = 1'b1;
            sg = sc;
        end
        if (m == 16'h0 && !rs) sg = 1'b0;
        return {sg, m, rs};
    endfunction

    task automatic drive(input logic [16:0] xa, xb, xc);
        @(negedge clk);
        a = xa; b = xb; c = xc;
        #1;
    endtask

    task automatic cmp(input string tag, input logic [16:0] act_y, input logic act_r,
                       input logic [17:0] exp_v);
        checks++;
        if ({act_y, act_r} !== exp_v) begin
            errors++;
            $display("FAIL %s: actual y=%h res=%b expected y=%h res=%b",
                     tag, act_y, act_r, exp_v[17:1], exp_v[0]);
        end
    endtask

    // One vector, u0 against the given expectation, all variants against u0's rules.
    task automatic vec(input string tag, input logic [16:0] xa, xb, xc, input logic [17:0] exp_v);
        drive(xa, xb, xc);
        cmp(tag, y0, r0, exp_v);
        cmp("R7 lookahead", y1, r1, exp_v);
        cmp("R7 select", y2, r2, exp_v);
        cmp("R7 prefix", y3, r3, exp_v);
    endtask

    task automatic t_idle();
        vec("R5 idle zero", 17'h0, 17'h0, 17'h0, 18'h0);
        vec("R8 same-cycle settle", 17'h08000, 17'h08000, 17'h04000, {17'h08000, 1'b0});
    endtask

    task automatic t_trunc();
        vec("R1 truncated to zero", 17'h00001, 17'h0FFFF, 17'h0, 18'h0);
        vec("R1 truncated to one", 17'h00003, 17'h08000, 17'h0, {17'h00001, 1'b0});
    endtask

    task automatic t_same_sign();
        vec("R2 positive add", 17'h08000, 17'h08000, 17'h04000, {17'h08000, 1'b0});
        vec("R2 negative add", 17'h18000, 17'h08000, 17'h11000, {17'h15000, 1'b0});
        vec("R2 both neg operands", 17'h18000, 17'h18000, 17'h00010, {17'h04010, 1'b0});
    endtask

    task automatic t_diff_pos();
        vec("R3 subtract positive", 17'h08000, 17'h08000, 17'h11000, {17'h03000, 1'b0});
        vec("R3 negative product", 17'h18000, 17'h08000, 17'h01000, {17'h13000, 1'b0});
    endtask

    task automatic t_diff_neg();
        vec("R4 negative result", 17'h04000, 17'h04000, 17'h13000, {17'h11FFF, 1'b1});
        vec("R4 minus one", 17'h04000, 17'h04000, 17'h11001, {17'h10000, 1'b1});
        vec("R4 positive C wins", 17'h14000, 17'h04000, 17'h03000, {17'h01FFF, 1'b1});
    endtask

    task automatic t_zero();
        vec("R5 cancel", 17'h18000, 17'h08000, 17'h04000, 18'h0);
        vec("R5 negative zeros", 17'h10000, 17'h01234, 17'h10000, 18'h0);
    endtask

    task automatic t_sat();
        vec("R6 saturate pos", 17'h0FFFF, 17'h0FFFF, 17'h00005, {17'h0FFFF, 1'b0});
        vec("R6 saturate neg", 17'h1FFFF, 17'h0FFFF, 17'h1FFFF, {17'h1FFFF, 1'b0});
    endtask

    task automatic t_sweep();
        logic [31:0] lf;
        lf = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            logic [16:0] xa, xb, xc;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            xa = lf[16:0];
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            xb = lf[20:4];
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            xc = lf[26:10];
            vec("R1 sweep", xa, xb, xc, model(xa, xb, xc));
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; c = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_trunc();
        t_same_sign();
        t_diff_pos();
        t_diff_neg();
        t_zero();
        t_sat();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule